// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block is the prioritising core of a per-processor interrupt controller. It keeps three 256-bit vectors: pending requests, interrupts in service, and the trigger mode last recorded for each vector. It also holds an 8-bit task priority and a 9-bit spurious/enable register. Requests arrive as a vector number with a level/edge flag. The processor takes the best pending vector with an acknowledge strobe and retires the current one with an end-of-interrupt strobe.

Priority is judged in 16 classes, where the class is the upper nibble of a vector. A pending vector signals the processor only when its class is strictly above the class of the processor priority. The processor priority is derived from the task priority and the highest vector in service. An acknowledge that the task priority masks returns the spurious vector and leaves all state alone.

Top module: `vp_core`

## Requirements
- R1: A request sets the pending bit of `req_vector`. It also sets that vector's trigger-mode bit when `req_level` is 1 and clears it when `req_level` is 0. `ack_level` reports the trigger-mode bit of the vector being acknowledged, and is 0 for a spurious result.
- R2: `ppr` equals `tpr_q` when `tpr_q[7:4]` is greater than or equal to the class of the highest in-service vector. Otherwise it is that class followed by four zero bits. An empty in-service set counts as class 0.
- R3: `irq_pending` is 1 only when all of these hold: `svr_q[8]` is 1, some vector is pending, and either `ppr` is 0 or the highest pending vector's class is strictly greater than `ppr[7:4]`.
- R4: An acknowledge returns `svr_q[7:0]` and changes no state in three cases: `svr_q[8]` is 0, nothing is pending, or `tpr_q` is nonzero and the highest pending vector is numerically at or below `tpr_q`. The in-service state is not consulted.
- R5: In every other case, an acknowledge returns the highest pending vector, clears its pending bit and sets its in-service bit.
- R6: An end-of-interrupt clears only the highest in-service bit. It has no effect when nothing is in service.
- R7: After reset: `tpr_q` is 0x00, `svr_q` is 0x0FF, nothing is pending or in service, all trigger-mode bits are 0, and `ack_done` is 0.
- R8: A spurious-register write keeps only `svr_wdata[8:0]`. A task-priority write stores all 8 bits.
- R9: A request arriving in the same cycle as an acknowledge is never lost, even when it names the vector being acknowledged. Set takes precedence over clear, for pending bits and for in-service bits alike.
- R10: `ack_vector` and `ack_level` are valid while `ack_done` is 1. `ack_done` is a one-cycle pulse, high in the cycle after each cycle in which `ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | 8 | Requested vector number |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack | input | 1 | Acknowledge strobe from the processor |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write enable |
| tpr_wdata | input | 8 | Task priority write data |
| svr_we | input | 1 | Spurious/enable register write enable |
| svr_wdata | input | 16 | Spurious/enable write data (bits 15:9 dropped) |
| irq_pending | output | 1 | Interrupt pending toward the processor |
| ack_done | output | 1 | Acknowledge result valid |
| ack_vector | output | 8 | Acknowledged or spurious vector |
| ack_level | output | 1 | Trigger mode of the acknowledged vector |
| ppr | output | 8 | Processor priority |
| tpr_q | output | 8 | Current task priority |
| svr_q | output | 9 | Current spurious/enable register |

## Verification
The priority-monotonic property on end-of-interrupt assumes that no acknowledge and no task-priority write fall in the same cycle. The bench only ever issues end-of-interrupt on its own. The remaining properties hold for any strobe pattern. The stimulus applies every strobe for a single cycle at a time, and combines request with acknowledge only in the deliberate same-cycle cases.

// File: rtl/vp_pkg.sv
// Package: shared constants for the vectored interrupt priority controller.
// Assumes vectors are 8 bits wide, so the priority class is the upper nibble.
package vp_pkg;
    localparam int CLS_W      = 4;        // width of a priority class
    localparam int SVR_W      = 9;        // kept bits of the spurious/enable register
    localparam int SVR_EN_BIT = 8;        // software enable position
    localparam logic [SVR_W-1:0] SVR_RST = 9'h0FF;
endpackage

// File: rtl/vp_find_top.sv
// Module: vp_find_top
// Finds the highest set bit of a wide vector. The vector is split into
// words; each word reports a hit and a local index; the highest hitting
// word wins. Purely combinational. Assumes WIDTH is a multiple of WORD_W
// and that there are at least two words.
module vp_find_top #(
    parameter int WIDTH  = 256,
    parameter int WORD_W = 32
) (
    input  logic [WIDTH-1:0]          vec_i,
    output logic                      found_o,
    output logic [$clog2(WIDTH)-1:0]  top_o
);
    localparam int NWORDS = WIDTH / WORD_W;
    localparam int LOC_W  = $clog2(WORD_W);
    localparam int WSEL_W = $clog2(NWORDS);

    logic [NWORDS-1:0]            hit;
    logic [NWORDS-1:0][LOC_W-1:0] loc;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [WORD_W-1:0] slice;
        logic [LOC_W-1:0]  loc_w;
        assign slice = vec_i[w*WORD_W +: WORD_W];
        // Highest set bit inside this word (later iterations override).
        always_comb begin
            loc_w = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (slice[b]) loc_w = LOC_W'(b);
            end
        end
        assign hit[w] = |slice;
        assign loc[w] = loc_w;
    end

    // Highest hitting word supplies the upper index bits.
    always_comb begin
        found_o = |hit;
        top_o   = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (hit[w]) top_o = {WSEL_W'(w), loc[w]};
        end
    end
endmodule

// File: rtl/vp_vec_bank.sv
// Module: vp_vec_bank
// Holds the pending, in-service and trigger-mode bit vectors, one flop
// per bit of each. A set of a bit takes precedence over a clear of the
// same bit in the same cycle. Assumes the take and retire indices are
// only asserted with their enables when the decision logic allows it.
module vp_vec_bank #(
    parameter int NUM_VEC = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [$clog2(NUM_VEC)-1:0]  set_idx,
    input  logic                        set_level,
    input  logic                        take_en,
    input  logic [$clog2(NUM_VEC)-1:0]  take_idx,
    input  logic                        retire_en,
    input  logic [$clog2(NUM_VEC)-1:0]  retire_idx,
    output logic [NUM_VEC-1:0]          irr_o,
    output logic [NUM_VEC-1:0]          isr_o,
    output logic [NUM_VEC-1:0]          tmr_o
);
    localparam int IW = $clog2(NUM_VEC);

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
        logic set_hit, take_hit, retire_hit;
        logic irr_r, isr_r, tmr_r;
        assign set_hit    = set_en    && (set_idx    == IW'(i));
        assign take_hit   = take_en   && (take_idx   == IW'(i));
        assign retire_hit = retire_en && (retire_idx == IW'(i));

        // Per-vector state update: clears first, sets override.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irr_r <= 1'b0;
                isr_r <= 1'b0;
                tmr_r <= 1'b0;
            end else begin
                if (take_hit)   irr_r <= 1'b0;
                if (set_hit)    irr_r <= 1'b1;
                if (retire_hit) isr_r <= 1'b0;
                if (take_hit)   isr_r <= 1'b1;
                if (set_hit)    tmr_r <= set_level;
            end
        end
        assign irr_o[i] = irr_r;
        assign isr_o[i] = isr_r;
        assign tmr_o[i] = tmr_r;
    end
endmodule

// File: rtl/vp_prio_calc.sv
// Module: vp_prio_calc
// Derives the processor priority, the pending decision and whether an
// acknowledge may take the top pending vector. Combinational; assumes
// 8-bit vectors whose class is the upper CLS_W bits.
module vp_prio_calc
    import vp_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             enable_i,
    input  logic             irr_found_i,
    input  logic [VEC_W-1:0] irr_top_i,
    input  logic             isr_found_i,
    input  logic [VEC_W-1:0] isr_top_i,
    output logic [VEC_W-1:0] ppr_o,
    output logic             pending_o,
    output logic             grant_ok_o
);
    localparam int LOW_W = VEC_W - CLS_W;

    logic [CLS_W-1:0] isr_cls;
    logic [CLS_W-1:0] irr_cls;

    // Processor priority from task priority and top in-service class.
    always_comb begin
        isr_cls = isr_found_i ? isr_top_i[VEC_W-1 -: CLS_W] : '0;
        if (tpr_i[VEC_W-1 -: CLS_W] >= isr_cls) ppr_o = tpr_i;
        else                                     ppr_o = {isr_cls, {LOW_W{1'b0}}};
    end

    // Pending line: enabled, something pending, class strictly above.
    always_comb begin
        irr_cls   = irr_top_i[VEC_W-1 -: CLS_W];
        pending_o = enable_i && irr_found_i &&
                    ((ppr_o == '0) || (irr_cls > ppr_o[VEC_W-1 -: CLS_W]));
    end

    // Acknowledge may take the top vector unless masked by task priority.
    always_comb begin
        grant_ok_o = enable_i && irr_found_i &&
                     !((tpr_i != '0) && (irr_top_i <= tpr_i));
    end
endmodule

// File: rtl/vp_core.sv
// Module: vp_core
// Top of the vectored interrupt priority controller. Registers task
// priority, spurious/enable and the acknowledge result; the vector bank
// holds per-vector state; two highest-bit finders feed the priority
// logic. Assumes NUM_VEC = 256 so vectors and the spurious field match.
module vp_core
    import vp_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [7:0]  req_vector,
    input  logic        req_level,
    input  logic        ack,
    input  logic        eoi,
    input  logic        tpr_we,
    input  logic [7:0]  tpr_wdata,
    input  logic        svr_we,
    input  logic [15:0] svr_wdata,
    output logic        irq_pending,
    output logic        ack_done,
    output logic [7:0]  ack_vector,
    output logic        ack_level,
    output logic [7:0]  ppr,
    output logic [7:0]  tpr_q,
    output logic [8:0]  svr_q
);
    localparam int VEC_W = $clog2(NUM_VEC);

    logic [NUM_VEC-1:0] irr, isr, tmr;
    logic               irr_found, isr_found;
    logic [VEC_W-1:0]   irr_top, isr_top;
    logic               grant_ok, take, retire;
    logic [VEC_W-1:0]   ppr_w;
    logic               pending_w;

    assign take   = ack && grant_ok;
    assign retire = eoi && isr_found;

    vp_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (req_valid),
        .set_idx    (req_vector),
        .set_level  (req_level),
        .take_en    (take),
        .take_idx   (irr_top),
        .retire_en  (retire),
        .retire_idx (isr_top),
        .irr_o      (irr),
        .isr_o      (isr),
        .tmr_o      (tmr)
    );

    vp_find_top #(.WIDTH(NUM_VEC), .WORD_W(WORD_W)) u_irr_top (
        .vec_i   (irr),
        .found_o (irr_found),
        .top_o   (irr_top)
    );

    vp_find_top #(.WIDTH(NUM_VEC), .WORD_W(WORD_W)) u_isr_top (
        .vec_i   (isr),
        .found_o (isr_found),
        .top_o   (isr_top)
    );

    vp_prio_calc #(.VEC_W(VEC_W)) u_prio (
        .tpr_i       (tpr_q),
        .enable_i    (svr_q[SVR_EN_BIT]),
        .irr_found_i (irr_found),
        .irr_top_i   (irr_top),
        .isr_found_i (isr_found),
        .isr_top_i   (isr_top),
        .ppr_o       (ppr_w),
        .pending_o   (pending_w),
        .grant_ok_o  (grant_ok)
    );

    assign ppr         = ppr_w;
    assign irq_pending = pending_w;

    // Software-visible priority and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q <= '0;
            svr_q <= SVR_RST;
        end else begin
            if (tpr_we) tpr_q <= tpr_wdata;
            if (svr_we) svr_q <= svr_wdata[SVR_W-1:0];
        end
    end

    // Acknowledge result: taken vector or spurious vector, one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_done   <= 1'b0;
            ack_vector <= '0;
            ack_level  <= 1'b0;
        end else begin
            ack_done <= ack;
            if (ack) begin
                ack_vector <= take ? irr_top : svr_q[VEC_W-1:0];
                ack_level  <= take ? tmr[irr_top] : 1'b0;
            end
        end
    end
endmodule

// File: rtl/vp_core_chk.sv
// Module: vp_core_chk
// Property checker for vp_core, attached by bind. Observes ports only.
module vp_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ack,
    input logic        eoi,
    input logic        tpr_we,
    input logic        svr_we,
    input logic [15:0] svr_wdata,
    input logic        irq_pending,
    input logic        ack_done,
    input logic [7:0]  ppr,
    input logic [7:0]  tpr_q,
    input logic [8:0]  svr_q
);
    // R3: pending is never raised while software enable is clear.
    a_r3_pending_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> svr_q[8]);

    // R2: processor priority never falls below task priority.
    a_r2_ppr_floor: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= tpr_q);

    // R6: a lone end-of-interrupt never raises the processor priority.
    a_r6_eoi_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && !tpr_we) |=> (ppr <= $past(ppr)));

    // R8: spurious register keeps the low nine written bits.
    a_r8_svr_write: assert property (@(posedge clk) disable iff (!rst_n)
        svr_we |=> (svr_q == $past(svr_wdata[8:0])));

    // R10: result valid follows every acknowledge cycle.
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ack_done);

    // R10: no result without a preceding acknowledge.
    a_r10_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !ack_done);
endmodule

bind vp_core vp_core_chk u_vp_core_chk (.*);

// File: tb/test_vp_core.sv
module test_vp_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic        req_level = 1'b0;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic        tpr_we = 1'b0;
    logic [7:0]  tpr_wdata = '0;
    logic        svr_we = 1'b0;
    logic [15:0] svr_wdata = '0;
    logic        irq_pending, ack_done, ack_level;
    logic [7:0]  ack_vector, ppr, tpr_q;
    logic [8:0]  svr_q;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [8:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vp_core i_vp_core (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_req(input logic [7:0] v, input logic lvl);
        req_valid = 1'b1; req_vector = v; req_level = lvl;
        step();
        req_valid = 1'b0;
    endtask

    // Driver: push the expected result, pulse acknowledge.
    task automatic do_ack(input logic [7:0] ev, input logic el);
        exp_q.push_back({el, ev});
        ack = 1'b1;
        step();
        ack = 1'b0;
        check("R10 ack_done pulse", ack_done, 1);
    endtask

    task automatic do_ack_req(input logic [7:0] ev, input logic el,
                              input logic [7:0] v, input logic lvl);
        exp_q.push_back({el, ev});
        ack = 1'b1; req_valid = 1'b1; req_vector = v; req_level = lvl;
        step();
        ack = 1'b0; req_valid = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1; step(); eoi = 1'b0;
    endtask

    task automatic do_tpr(input logic [7:0] d);
        tpr_we = 1'b1; tpr_wdata = d; step(); tpr_we = 1'b0;
    endtask

    task automatic do_svr(input logic [15:0] d);
        svr_we = 1'b1; svr_wdata = d; step(); svr_we = 1'b0;
    endtask

    // Monitor: pop and compare each acknowledge result.
    always @(negedge clk) begin
        if (rst_n && ack_done) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R10 unexpected result actual=%0h expected=none", ack_vector);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check("R5 ack vector", ack_vector, e[7:0]);
                check("R1 ack level", ack_level, e[8]);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 tpr reset", tpr_q, 8'h00);
        check("R7 svr reset", svr_q, 9'h0FF);
        check("R7 ppr reset", ppr, 0);
        check("R7 pending reset", irq_pending, 0);
        check("R7 ack_done reset", ack_done, 0);

        // Disabled: pending held low, ack gives spurious and keeps state.
        do_req(8'h45, 1'b0);
        check("R3 disabled no pending", irq_pending, 0);
        do_ack(8'hFF, 1'b0);                          // R4 disabled spurious
        do_svr(16'hFF1F);
        check("R8 svr masked", svr_q, 9'h11F);
        check("R3 enabled pending", irq_pending, 1);
        do_ack(8'h45, 1'b0);                          // R5 taken
        check("R2 ppr isr class", ppr, 8'h40);
        check("R3 none above", irq_pending, 0);

        do_req(8'h30, 1'b0);
        check("R3 lower class blocked", irq_pending, 0);
        do_req(8'h52, 1'b1);
        check("R3 higher class pends", irq_pending, 1);
        do_ack(8'h52, 1'b1);                          // R1 level recorded
        check("R2 ppr 0x50", ppr, 8'h50);
        do_eoi();
        check("R6 top retired only", ppr, 8'h40);
        check("R3 still blocked", irq_pending, 0);
        do_eoi();
        check("R6 isr empty ppr", ppr, 8'h00);
        check("R3 class0 ppr pends", irq_pending, 1);
        do_eoi();
        check("R6 empty eoi no effect ppr", ppr, 8'h00);
        check("R6 empty eoi no effect pend", irq_pending, 1);

        // Task priority masking.
        do_tpr(8'h30);
        check("R8 tpr write", tpr_q, 8'h30);
        check("R2 ppr from tpr", ppr, 8'h30);
        check("R3 tpr blocks", irq_pending, 0);
        do_ack(8'h1F, 1'b0);                          // R4 masked spurious
        do_tpr(8'h20);
        check("R4 irr kept after spurious", irq_pending, 1);
        do_ack(8'h30, 1'b0);
        check("R2 isr class over tpr", ppr, 8'h30);
        do_eoi();
        check("R2 back to tpr", ppr, 8'h20);

        do_tpr(8'h35);
        do_req(8'h36, 1'b0);
        check("R3 equal class blocked", irq_pending, 0);
        do_ack(8'h36, 1'b0);                          // R4 above tpr is taken
        check("R2 equal class keeps tpr", ppr, 8'h35);
        do_req(8'h35, 1'b0);
        do_ack(8'h1F, 1'b0);                          // R4 at tpr is spurious
        do_tpr(8'h00);
        check("R2 ppr isr class 3", ppr, 8'h30);
        check("R3 blocked by isr", irq_pending, 0);
        do_eoi();
        check("R3 pends after eoi", irq_pending, 1);
        do_ack(8'h35, 1'b0);
        do_eoi();
        check("R6 all retired", ppr, 8'h00);
        check("R3 nothing left", irq_pending, 0);

        // R9: request alongside acknowledge.
        do_req(8'h80, 1'b0);
        do_ack_req(8'h80, 1'b0, 8'h90, 1'b0);
        check("R9 new request kept", irq_pending, 1);
        do_ack(8'h90, 1'b0);
        check("R2 ppr 0x90", ppr, 8'h90);
        do_eoi();
        do_eoi();
        check("R6 cleared", ppr, 8'h00);

        // R9: same vector re-requested while acknowledged; set wins.
        do_req(8'hA0, 1'b1);
        do_ack_req(8'hA0, 1'b1, 8'hA0, 1'b0);
        check("R9 same vector ppr", ppr, 8'hA0);
        check("R9 same vector held", irq_pending, 0);
        do_eoi();
        check("R9 same vector repends", irq_pending, 1);
        do_ack(8'hA0, 1'b0);                          // R1 trigger mode cleared
        do_eoi();

        // R1: later edge request clears level mode.
        do_req(8'h60, 1'b1);
        do_req(8'h60, 1'b0);
        do_ack(8'h60, 1'b0);
        do_eoi();

        // R5: highest across words.
        do_req(8'h01, 1'b1);
        do_req(8'hFE, 1'b0);
        do_req(8'h7F, 1'b1);
        do_ack(8'hFE, 1'b0);
        do_ack(8'h7F, 1'b1);
        check("R2 ppr 0xF0", ppr, 8'hF0);
        do_eoi();
        check("R6 highest retired first", ppr, 8'h70);
        do_eoi();
        check("R3 class0 pends", irq_pending, 1);
        do_ack(8'h01, 1'b1);
        do_eoi();
        check("R6 final ppr", ppr, 8'h00);

        do_svr(16'h00FF);
        check("R8 disable", svr_q, 9'h0FF);
        repeat (2) step();
        check("R10 queue drained", exp_q.size(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule